// File: doc/BRIEF.md
# NAND Hamming ECC generator

This block computes the three-byte single-error-correcting Hamming code that protects one step of NAND page data. A step is 256 or 512 bytes. The host marks the start of a step with a one-cycle `start_i` pulse. It then streams bytes with a `valid_i` strobe. The block counts byte addresses itself. For each accepted byte it updates a set of row parities, indexed by byte address, and a running XOR of the bytes, which later yields the column parities.

Once the final byte of the step has been accepted, `done_o` pulses for one cycle. `code_o` then carries the finished code and holds it until the next start. Every code bit is an inverted parity, so it reads 1 when the bits it covers hold an even number of ones.

Two things can change at run time:
- `big_step_i` selects the step length. It is sampled at start.
- `sm_order_i` selects which of the two row-parity bytes appears first. It acts directly on the output.

Row parity pairs are defined per address bit k. The even member covers the bytes whose address bit k is 0, and the odd member covers the bytes whose address bit k is 1. Only the even members and the overall parity are accumulated. Each odd member is the overall parity XOR its even partner.

Top module: `nand_ham_ecc_gen`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0 and `code_o` is 24'hFFFFFF, which is the code of empty accumulators.
- R2: A cycle with `start_i` high clears the byte counter and all parities and samples `big_step_i` (1 = 512-byte step, 0 = 256-byte step). Any byte presented in that same cycle is not accepted, and later changes of `big_step_i` do not affect the step.
- R3: A byte is accepted only in a cycle with `valid_i` high while a step is open. Bytes offered with `valid_i` low, or after the step has completed, leave `code_o` unchanged.
- R4: `done_o` is high for exactly the one cycle that follows the edge at which the 256th (or 512th) byte of the step is accepted.
- R5: Row parity bit pair k (k = 0..7) sits at `code_o` bits 2k and 2k+1 of the row-parity word, where k = 0..3 form one byte and k = 4..7 form the other. Bit 2k is the inverted XOR of all bits of bytes with address bit k = 0, and bit 2k+1 is the same over bytes with address bit k = 1.
- R6: `code_o[23:18]` hold the inverted column parities over all bytes of the step, using the masks F0, 0F, CC, 33, AA, 55 in that order from bit 23 down to bit 18.
- R7: `code_o[17:16]` are 2'b11 for a 256-byte step. For a 512-byte step, bit 17 is the inverted parity of bytes with address bit 8 = 1, and bit 16 is the inverted parity of bytes with address bit 8 = 0.
- R8: When `sm_order_i` is 1, `code_o[7:0]` holds row pairs k = 0..3 and `code_o[15:8]` holds k = 4..7. When it is 0, the two bytes are swapped. A change of `sm_order_i` takes effect in the same cycle.
- R9: After `done_o`, `code_o` holds its value, apart from the ordering of R8, until the next `start_i`.
- R10: A `start_i` in the middle of a step abandons it, and the following step's code depends only on bytes accepted after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new step and clears the parities |
| valid_i | input | 1 | Byte strobe for `data_i` |
| data_i | input | 8 | Data byte |
| big_step_i | input | 1 | Step length select, sampled at start: 1 = 512 bytes, 0 = 256 bytes |
| sm_order_i | input | 1 | Row-parity byte ordering select |
| done_o | output | 1 | One-cycle pulse after the last byte of a step |
| code_o | output | 24 | Code bytes: byte 0 in [7:0], byte 1 in [15:8], byte 2 in [23:16] |

## Verification
The bench builds the block with its default parameters: a 9-bit address counter and 8-bit bytes. With these values both step lengths can be run, so the spare bits 17:16 are seen both as constant ones and as the parities of address bit 8.

A behavioural model recomputes the full code from a queue of accepted bytes on every clock. This covers partial steps, aborted steps, gapped streams and bytes arriving after completion.

Hand-computed single-bit patterns are also checked. The bit positions are chosen so that the two row-parity bytes differ, which makes an ordering swap visible at the ports.

// File: rtl/nham_pkg.sv
package nham_pkg;
  localparam int BYTE_W  = 8;
  localparam int COL_N   = $clog2(BYTE_W);
  localparam int CODE_W  = 3 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/nham_step_ctrl.sv
module nham_step_ctrl #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              big_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              big_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_LONG  = '1;
  localparam logic [ADDR_W-1:0] LAST_SHORT = {1'b0, {(ADDR_W-1){1'b1}}};

  logic              active_q, big_q, done_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              at_last;

  assign at_last  = (cnt_q == (big_q ? LAST_LONG : LAST_SHORT));
  assign accept_o = active_q & valid_i & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      big_q    <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= accept_o & at_last;
      if (start_i) begin
        active_q <= 1'b1;
        big_q    <= big_i;
        cnt_q    <= '0;
      end else if (accept_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (at_last) active_q <= 1'b0;
      end
    end
  end

  assign addr_o = cnt_q;
  assign big_o  = big_q;
  assign done_o = done_q;
endmodule

// File: rtl/nham_parity_acc.sv
module nham_parity_acc
  import nham_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             data_i,
  output byte_t             col_o,
  output logic [ADDR_W-1:0] row_even_o
);
  byte_t col_q;
  logic  byte_par;

  assign byte_par = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      col_q <= '0;
    else if (clear_i) col_q <= '0;
    else if (acc_i)   col_q <= col_q ^ data_i;
  end

  // even member of each row pair: bytes whose address bit k is 0
  for (genvar k = 0; k < ADDR_W; k++) begin : g_row
    logic row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     row_q <= 1'b0;
      else if (clear_i)                row_q <= 1'b0;
      else if (acc_i && !addr_i[k])    row_q <= row_q ^ byte_par;
    end
    assign row_even_o[k] = row_q;
  end

  assign col_o = col_q;
endmodule

// File: rtl/nham_code_fmt.sv
module nham_code_fmt
  import nham_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  byte_t              col_i,
  input  logic [ADDR_W-1:0]  row_even_i,
  input  logic               big_i,
  input  logic               sm_order_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int PAIRS = ADDR_W - 1;

  logic                 tot;
  logic [2*PAIRS-1:0]   rows;
  byte_t                cbyte;

  always_comb begin
    tot = ^col_i;
    for (int k = 0; k < PAIRS; k++) begin
      rows[2*k]   = ~row_even_i[k];
      rows[2*k+1] = ~(tot ^ row_even_i[k]);
    end
    cbyte = '0;
    for (int j = 0; j < COL_N; j++) begin
      for (int h = 0; h < 2; h++) begin
        logic cp;
        cp = 1'b0;
        for (int b = 0; b < BYTE_W; b++)
          if (((b >> j) & 1) == h) cp = cp ^ col_i[b];
        cbyte[2 + 2*j + h] = ~cp;
      end
    end
    cbyte[1:0] = big_i ? {~(tot ^ row_even_i[ADDR_W-1]), ~row_even_i[ADDR_W-1]}
                       : 2'b11;
  end

  assign code_o = sm_order_i ? {cbyte, rows[15:8], rows[7:0]}
                             : {cbyte, rows[7:0], rows[15:8]};
endmodule

// File: rtl/nand_ham_ecc_gen.sv
module nand_ham_ecc_gen
  import nham_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              big_step_i,
  input  logic              sm_order_i,
  output logic              done_o,
  output logic [23:0]       code_o
);
  logic              accept;
  logic [ADDR_W-1:0] addr;
  logic              big;
  byte_t             col;
  logic [ADDR_W-1:0] row_even;

  nham_step_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .big_i    (big_step_i),
    .accept_o (accept),
    .addr_o   (addr),
    .big_o    (big),
    .done_o   (done_o)
  );

  nham_parity_acc #(.ADDR_W(ADDR_W)) i_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i),
    .acc_i      (accept),
    .addr_i     (addr),
    .data_i     (data_i),
    .col_o      (col),
    .row_even_o (row_even)
  );

  nham_code_fmt #(.ADDR_W(ADDR_W)) i_fmt (
    .col_i      (col),
    .row_even_i (row_even),
    .big_i      (big),
    .sm_order_i (sm_order_i),
    .code_o     (code_o)
  );
endmodule

// File: rtl/nham_ecc_chk.sv
module nham_ecc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        valid_i,
  input logic        big_step_i,
  input logic        sm_order_i,
  input logic        done_o,
  input logic [23:0] code_o
);
  logic held_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (start_i) begin
        held_q <= 1'b0;
        mode_q <= big_step_i;
      end else if (done_o) held_q <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(valid_i) && !$past(start_i))); // R4
  AST_SPARE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (code_o[17:16] == 2'b11)); // R7
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !start_i) |=> ((code_o == $past(code_o)) || (sm_order_i != $past(sm_order_i)))); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=> ((sm_order_i != $past(sm_order_i)) || $stable(code_o))); // R3
  AST_ORDER_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=> ((sm_order_i == $past(sm_order_i)) ||
      ((code_o[7:0] == $past(code_o[15:8])) && (code_o[15:8] == $past(code_o[7:0]))
       && (code_o[23:16] == $past(code_o[23:16]))))); // R8
endmodule

bind nand_ham_ecc_gen nham_ecc_chk i_nham_ecc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .valid_i    (valid_i),
  .big_step_i (big_step_i),
  .sm_order_i (sm_order_i),
  .done_o     (done_o),
  .code_o     (code_o)
);

// File: tb/test_nand_ham_ecc_gen.sv
`timescale 1ns/1ps
module test_nand_ham_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, valid, big, sm;
  logic [7:0]  data;
  logic        done_o;
  logic [23:0] code_o;

  always #2.5 clk = ~clk;

  nand_ham_ecc_gen i_nand_ham_ecc_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .data_i(data), .big_step_i(big), .sm_order_i(sm),
    .done_o(done_o), .code_o(code_o)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";
  logic [7:0] mem [512];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] q[$];
  bit m_active = 0, m_big = 0, m_done = 0;

  function automatic logic [23:0] ref_code(input bit bg, input bit so);
    bit rp[18];
    bit cp[6];
    logic [7:0] a, b, c;
    foreach (rp[i]) rp[i] = 0;
    foreach (cp[i]) cp[i] = 0;
    for (int i = 0; i < q.size(); i++) begin
      bit p = ^q[i];
      for (int k = 0; k < 9; k++)
        if ((i >> k) & 1) rp[2*k+1] ^= p; else rp[2*k] ^= p;
      for (int bi = 0; bi < 8; bi++)
        for (int j = 0; j < 3; j++)
          if ((bi >> j) & 1) cp[2*j+1] ^= q[i][bi]; else cp[2*j] ^= q[i][bi];
    end
    for (int i = 0; i < 8; i++) begin
      a[i] = ~rp[i];
      b[i] = ~rp[8+i];
    end
    for (int i = 0; i < 6; i++) c[2+i] = ~cp[i];
    c[1:0] = bg ? {~rp[17], ~rp[16]} : 2'b11;
    return so ? {c, b, a} : {c, a, b};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_active = 0; m_big = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (start) begin
        q.delete(); m_active = 1; m_big = big;
      end else if (m_active && valid) begin
        q.push_back(data);
        if (q.size() == (m_big ? 512 : 256)) begin
          m_active = 0; m_done = 1;
        end
      end
    end
    #1;
    if (rst_n) begin
      chk(done_o === m_done, "R4", "done", {23'd0, done_o}, {23'd0, m_done});
      chk(code_o === ref_code(m_big, sm), tag, "code", code_o, ref_code(m_big, sm));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); start = 0; valid = 0; data = 8'($urandom);
    end
  endtask

  task automatic pulse_start(input bit bg, input bit with_byte);
    @(negedge clk); start = 1; big = bg; valid = with_byte; data = 8'hC3;
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && ($urandom % gap) == 0) idle(1 + $urandom % 3);
      @(negedge clk); start = 0; valid = 1; data = mem[i];
    end
  endtask

  // one full step; checks the done pulse at the ports
  task automatic run_step(input bit bg, input int gap);
    pulse_start(bg, 0);
    feed(bg ? 512 : 256, gap);
    @(negedge clk); start = 0; valid = 0; #1;
    chk(done_o === 1'b1, "R4", "done after last byte", {23'd0, done_o}, 24'd1);
    @(negedge clk); #1;
    chk(done_o === 1'b0, "R4", "done one cycle", {23'd0, done_o}, 24'd0);
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  initial begin
    #(200000 * 5.0);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] saved;
    rst_n = 0; start = 0; valid = 0; big = 0; sm = 1; data = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(done_o === 1'b0, "R1", "reset done", {23'd0, done_o}, 24'd0);
    chk(code_o === 24'hFFFFFF, "R1", "reset code", code_o, 24'hFFFFFF);
    @(negedge clk); rst_n = 1;
    idle(2);

    tag = "R5";
    clr_mem(); mem[0] = 8'h01;
    run_step(0, 0); #1;
    chk(code_o === 24'hABAAAA, "R5", "bit0 at addr 0", code_o, 24'hABAAAA);

    tag = "R6";
    clr_mem(); mem[255] = 8'h80;
    run_step(0, 0); #1;
    chk(code_o === 24'h575555, "R6", "bit7 at addr 255", code_o, 24'h575555);

    tag = "R8";
    clr_mem(); mem[15] = 8'h01;
    run_step(0, 0); #1;
    chk(code_o === 24'hABAA55, "R8", "smart order", code_o, 24'hABAA55);
    @(negedge clk); sm = 0; #1;
    chk(code_o === 24'hAB55AA, "R8", "regular order", code_o, 24'hAB55AA);
    idle(2); sm = 1;

    tag = "R7";
    clr_mem(); mem[256] = 8'h01;
    run_step(1, 0); #1;
    chk(code_o === 24'hA9AAAA, "R7", "512 step spare bits", code_o, 24'hA9AAAA);

    tag = "R3";
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    run_step(0, 5);
    run_step(1, 7);

    tag = "R9";
    saved = code_o;
    feed(40, 3);
    idle(3); #1;
    chk(code_o === saved, "R9", "hold after done", code_o, saved);
    chk(done_o === 1'b0, "R9", "no done after step", {23'd0, done_o}, 24'd0);

    tag = "R2";
    pulse_start(0, 1);
    @(negedge clk); big = 1; start = 0; valid = 0;
    clr_mem(); mem[0] = 8'h01;
    feed(256, 0);
    idle(2); #1;
    chk(code_o === 24'hABAAAA, "R2", "start byte ignored, mode latched", code_o, 24'hABAAAA);
    big = 0;

    tag = "R10";
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    pulse_start(0, 0);
    feed(100, 0);
    clr_mem(); mem[255] = 8'h80;
    run_step(0, 0); #1;
    chk(code_o === 24'h575555, "R10", "abort restarts", code_o, 24'h575555);

    tag = "R8";
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    pulse_start(1, 0);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); start = 0; valid = 1; data = mem[i]; sm = 1'($urandom);
    end
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule